// File: doc/BRIEF.md
# Ancillary Word Buffer with Occupancy Flags

This block is a single-clock first-in first-out store that holds ancillary packet words between a packet extractor and a host. The extractor pushes one word per cycle through the write port. The host pops words through the read port. Before the store can fill, an early-warning flag tells the host to begin draining it.

The buffer drives four flags: empty, almost-full (at 90% of capacity), full, and a sticky overrun. A push into a full store is dropped and sets overrun. Overrun stays set until the host performs a status read. The status read captures all four flags into a status word and clears overrun. To recover from an overrun, the host issues a flush, which discards every stored word and resets the pointers.

Top module: `anc_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `almost_full`=0, `overrun`=0, `rd_data`=0 and `stat_data`=0. `empty` and `full` are never both 1.
- R2: `almost_full` is 1 exactly when the stored word count is at least ceil(0.9 × DEPTH), which is 231 for DEPTH=256.
- R3: `full` is 1 exactly when DEPTH words are stored.
- R4: A push (`wr_en`=1) while `full`=1 and `flush`=0 sets `overrun` at the next edge. The pushed word is dropped, and the stored words and their order are unchanged.
- R5: Once set, `overrun` stays 1 until a cycle with `stat_rd`=1. That cycle clears it at the next edge, unless a new overrun occurs in the same cycle, in which case it stays set.
- R6: The cycle after `stat_rd`=1, `stat_data` holds the flags sampled in the strobe cycle. The encoding is bit 0 = empty, bit 1 = almost_full, bit 2 = full, bit 3 = overrun. Between strobes, `stat_data` keeps its value.
- R7: `flush`=1 discards all stored words, so `empty`=1 after the next edge. A push or pop in the same cycle as `flush` has no effect.
- R8: A pop (`rd_en`=1) while not empty places the oldest stored word on `rd_data` at the next edge. Words leave in the order they were pushed.
- R9: A pop while `empty`=1 is ignored, and `rd_data` keeps its last value.
- R10: A push and a pop in the same cycle, when the store is neither empty nor full, leave the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push strobe from the extractor |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | DW | Last popped word |
| flush | input | 1 | Discard contents and reset pointers |
| stat_rd | input | 1 | Status read strobe; clears overrun |
| stat_data | output | 4 | Captured status {overrun, full, almost_full, empty} |
| empty | output | 1 | No words stored |
| almost_full | output | 1 | Count at or above the 90% threshold |
| full | output | 1 | All locations occupied |
| overrun | output | 1 | Sticky: a push was attempted while full |

## Verification
The properties assume that every strobe is a clean synchronous level that changes only between clock edges. They also assume that `flush` may coincide with any other strobe, and the overrun and flush properties are written to allow for that. The stimulus changes inputs shortly after each rising edge. It drives pushes past capacity on purpose, pops past empty on purpose, and asserts flush together with a push. This keeps every corner the properties describe inside the exercised space.

// File: rtl/anc_fifo.sv
module anc_fifo #(
  parameter int DW    = 10,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          flush,
  input  logic          stat_rd,
  output logic [3:0]    stat_data,
  output logic          empty,
  output logic          almost_full,
  output logic          full,
  output logic          overrun
);
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = AW + 1;
  localparam int AF_LVL = (DEPTH * 9 + 9) / 10;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty       = (cnt == '0);
  assign full        = (cnt == CW'(DEPTH));
  assign almost_full = (cnt >= CW'(AF_LVL));

  wire do_wr = wr_en & ~full & ~flush;
  wire do_rd = rd_en & ~empty & ~flush;

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        overrun <= 1'b0;
    else if (wr_en && full && !flush)  overrun <= 1'b1;
    else if (stat_rd)                  overrun <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       stat_data <= '0;
    else if (stat_rd) stat_data <= {overrun, full, almost_full, empty};
  end
endmodule

module anc_fifo_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          flush,
  input logic          stat_rd,
  input logic [3:0]    stat_data,
  input logic          empty,
  input logic          almost_full,
  input logic          full,
  input logic          overrun
);
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full)); // R1
  AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n) full |-> almost_full); // R2
  AST_FULL_HOLDS_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n) full && wr_en && !rd_en && !flush |=> full); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) wr_en && full && !flush |=> overrun); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun && !stat_rd |=> overrun); // R5
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) stat_rd && !(wr_en && full && !flush) |=> !overrun); // R5
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !stat_rd |=> $stable(stat_data)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty && !almost_full); // R7
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) empty && rd_en |=> $stable(rd_data)); // R9
endmodule

bind anc_fifo anc_fifo_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .flush(flush), .stat_rd(stat_rd), .stat_data(stat_data), .empty(empty),
  .almost_full(almost_full), .full(full), .overrun(overrun)
);

// File: tb/anc_fifo_tb.sv
module anc_fifo_tb;
  localparam int DW = 10;
  localparam int DEPTH = 256;
  localparam int AFL = 231;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, flush = 0, stat_rd = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [3:0] stat_data;
  logic empty, almost_full, full, overrun;

  int nvec = 0, nerr = 0, mcnt = 0;
  logic [DW-1:0] q[$];
  bit done = 0;

  always #2 clk = ~clk;

  anc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .flush(flush), .stat_rd(stat_rd), .stat_data(stat_data),
    .empty(empty), .almost_full(almost_full), .full(full), .overrun(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic push(logic [DW-1:0] v);
    wr_en = 1; wr_data = v;
    if (mcnt < DEPTH) begin q.push_back(v); mcnt++; end
    cyc();
    wr_en = 0;
  endtask

  task automatic pop_chk(string req);
    logic [DW-1:0] e;
    e = q.pop_front(); mcnt--;
    rd_en = 1; cyc(); rd_en = 0;
    chk(req, rd_data, e);
  endtask

  task automatic t_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 af", almost_full, 0); chk("R1 ovr", overrun, 0);
    chk("R1 rd_data", rd_data, 0); chk("R1 stat", stat_data, 0);
  endtask

  task automatic t_fill();
    for (int i = 1; i <= DEPTH; i++) begin
      push(DW'(i * 7 + 3));
      if (i == AFL - 1) chk("R2 below threshold", almost_full, 0);
      if (i == AFL) chk("R2 at threshold", almost_full, 1);
      if (i == DEPTH - 1) chk("R3 one short", full, 0);
    end
    chk("R3 full", full, 1);
    chk("R1 not empty", empty, 0);
  endtask

  task automatic t_overrun();
    push(10'h3FF);
    chk("R4 overrun set", overrun, 1);
    chk("R4 still full", full, 1);
    cyc(); cyc();
    chk("R5 sticky", overrun, 1);
  endtask

  task automatic t_status();
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R6 status word", stat_data, 4'b1110);
    chk("R5 cleared", overrun, 0);
    cyc();
    chk("R6 status held", stat_data, 4'b1110);
  endtask

  task automatic t_drain();
    while (mcnt > 0) pop_chk("R8 order / R4 drop");
    chk("R1 empty after drain", empty, 1);
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] last;
    last = rd_data;
    rd_en = 1; cyc(); cyc(); rd_en = 0;
    chk("R9 hold", rd_data, last);
    chk("R9 empty", empty, 1);
  endtask

  task automatic t_rdwr();
    for (int i = 0; i < AFL - 1; i++) push(DW'(i + 100));
    chk("R10 pre", almost_full, 0);
    for (int k = 0; k < 5; k++) begin
      logic [DW-1:0] e;
      e = q.pop_front();
      q.push_back(DW'(k + 900));
      rd_en = 1; wr_en = 1; wr_data = DW'(k + 900);
      cyc();
      rd_en = 0; wr_en = 0;
      chk("R10 order", rd_data, e);
    end
    chk("R10 count kept", almost_full, 0);
    push(10'h155);
    chk("R10 count +1 reaches threshold", almost_full, 1);
  endtask

  task automatic t_flush();
    flush = 1; wr_en = 1; wr_data = 10'h2AA; cyc(); flush = 0; wr_en = 0;
    q.delete(); mcnt = 0;
    chk("R7 empty", empty, 1); chk("R7 af", almost_full, 0);
    push(10'h011); push(10'h022);
    pop_chk("R7 after flush"); pop_chk("R7 after flush");
    chk("R7 empty again", empty, 1);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_overrun();
    t_status();
    t_drain();
    t_empty_read();
    t_rdwr();
    t_flush();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; nvec++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule